// File: doc/BRIEF.md
# High-Side Edge-Triggered Gate Output Latch

This block models the digital control path that decides when the two gate outputs of a half-bridge driver may be on. The high-side output does not follow its command level. Each rising command edge starts a turn-on pulse and each falling edge starts a turn-off pulse. A pulse reaches the set/reset latch that drives the high-side output only after it has stayed active for a minimum number of cycles, so short command glitches cannot change the latch. The low-side output follows its command level directly.

Both supplies arrive as digital undervoltage flags. A supply counts as valid only after its flag has been low for a set number of consecutive cycles. The floating high-side supply must be valid before a rising command edge is sampled, or that edge is lost and the output waits for the next one. Losing the high-side supply clears the latch. All times are given in nanoseconds and converted to clock cycles. With the defaults (100 MHz, 70 ns pulse, 40 ns filter), a pulse is 7 cycles long and the filter needs 4 cycles.

Top module: `hs_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, both outputs are low, whatever the commands and flags are.
- R2: With the high-side supply valid, a rising `hs_cmd` that is first seen high at clock edge k drives `hs_out` high from edge k+4 (the filter length), and `hs_out` stays high while the command stays high.
- R3: A falling `hs_cmd` that is first seen low at edge k drives `hs_out` low from edge k+4.
- R4: A high or low excursion of `hs_cmd` that lasts fewer than 4 cycles leaves `hs_out` unchanged.
- R5: The high-side supply becomes valid once `hs_uv` has been sampled low on 20 consecutive edges. A rising edge sampled before that is ignored, and `hs_out` stays low until the next rising edge.
- R6: While `hs_uv` is high, `hs_out` is low in the same cycle. The latch is cleared, so `hs_out` comes back only after a new rising edge.
- R7: `ls_out` equals `ls_cmd` once `ls_uv` has been sampled low on 30 consecutive edges. It is low while `ls_uv` is high and during that count.
- R8: The turn-on and turn-off pulses are never active together: a newer command edge cancels the pulse of the older one, and turn-off wins over turn-on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_cmd | input | 1 | Conditioned high-side command |
| ls_cmd | input | 1 | Low-side command |
| hs_uv | input | 1 | High-side supply undervoltage flag, 1 = below threshold |
| ls_uv | input | 1 | Low-side supply undervoltage flag, 1 = below threshold |
| hs_out | output | 1 | High-side gate output |
| ls_out | output | 1 | Low-side gate output |

## Verification
The embedded assertions check, on every cycle, that an undervoltage flag forces its output low, that the low-side output never turns on right after an undervoltage cycle, that the two pulses never overlap, and that the high-side output rises only right after a turn-on pulse. The exact latency of each edge, the rejection of short glitches, the loss of an edge that arrives before the supply is valid, and the edge on which each qualification delay ends can only be shown by the bench's timed scenarios.

// File: rtl/hs_gate_ctrl.sv
module hs_gate_ctrl #(
  parameter int CLK_MHZ    = 100,
  parameter int PULSE_NS   = 70,
  parameter int FILT_NS    = 40,
  parameter int HS_DLY_CYC = 20,
  parameter int LS_DLY_CYC = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_cmd,
  input  logic ls_cmd,
  input  logic hs_uv,
  input  logic ls_uv,
  output logic hs_out,
  output logic ls_out
);

  localparam int PULSE_CYC = PULSE_NS * CLK_MHZ / 1000;
  localparam int FILT_CYC  = FILT_NS * CLK_MHZ / 1000;
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam int HW = $clog2(HS_DLY_CYC + 1);
  localparam int LW = $clog2(LS_DLY_CYC + 1);

  logic [HW-1:0] hs_cnt;
  logic [LW-1:0] ls_cnt;
  logic [PW-1:0] on_cnt, off_cnt;
  logic [FW-1:0] on_run, off_run;
  logic          cmd_q, latch_q;

  wire hs_ok    = !hs_uv && (hs_cnt == HW'(HS_DLY_CYC));
  wire ls_ok    = !ls_uv && (ls_cnt == LW'(LS_DLY_CYC));
  wire rise     = hs_cmd && !cmd_q;
  wire fall     = !hs_cmd && cmd_q;
  wire on_puls  = on_cnt != '0;
  wire off_puls = off_cnt != '0;
  wire on_fire  = on_puls && (on_run == FW'(FILT_CYC - 1));
  wire off_fire = off_puls && (off_run == FW'(FILT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_cnt <= '0;
      ls_cnt <= '0;
    end else begin
      if (hs_uv) hs_cnt <= '0;
      else if (hs_cnt != HW'(HS_DLY_CYC)) hs_cnt <= hs_cnt + 1'b1;
      if (ls_uv) ls_cnt <= '0;
      else if (ls_cnt != LW'(LS_DLY_CYC)) ls_cnt <= ls_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= 1'b0;
      on_cnt  <= '0;
      off_cnt <= '0;
    end else begin
      cmd_q <= hs_cmd;
      if (!hs_ok || fall)   on_cnt <= '0;
      else if (rise)        on_cnt <= PW'(PULSE_CYC);
      else if (on_puls)     on_cnt <= on_cnt - 1'b1;
      if (rise)             off_cnt <= '0;
      else if (fall)        off_cnt <= PW'(PULSE_CYC);
      else if (off_puls)    off_cnt <= off_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_run  <= '0;
      off_run <= '0;
      latch_q <= 1'b0;
    end else begin
      on_run  <= !on_puls  ? '0 : (on_run  == FW'(FILT_CYC)) ? on_run  : on_run  + 1'b1;
      off_run <= !off_puls ? '0 : (off_run == FW'(FILT_CYC)) ? off_run : off_run + 1'b1;
      if (!hs_ok || off_fire) latch_q <= 1'b0;
      else if (on_fire)       latch_q <= 1'b1;
    end
  end

  assign hs_out = rst_n && latch_q && hs_ok;
  assign ls_out = rst_n && ls_cmd && ls_ok;

  a_r6_hs_uv_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    hs_uv |-> !hs_out);
  a_r7_ls_uv_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    ls_uv |-> !ls_out);
  a_r7_ls_waits_after_uv: assert property (@(posedge clk) disable iff (!rst_n)
    ls_out |-> $past(!ls_uv));
  a_r8_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(on_puls && off_puls));
  a_r2_rise_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_out) |-> $past(on_puls));

endmodule

// File: tb/hs_gate_ctrl_test.sv
module hs_gate_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hs_cmd = 1'b0, ls_cmd = 1'b0, hs_uv = 1'b0, ls_uv = 1'b0;
  logic hs_out, ls_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hs_gate_ctrl uut (.clk(clk), .rst_n(rst_n), .hs_cmd(hs_cmd), .ls_cmd(ls_cmd),
                    .hs_uv(hs_uv), .ls_uv(ls_uv), .hs_out(hs_out), .ls_out(ls_out));

  typedef struct packed {
    logic       hs;
    logic       ls;
    logic       luv;
    logic [7:0] hold;
    logic       ehs;
    logic       els;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{1'b0, 1'b0, 1'b0, 8'd2,  1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 8'd4,  1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 8'd1,  1'b1, 1'b0},
    '{1'b1, 1'b1, 1'b0, 8'd3,  1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 8'd4,  1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 8'd1,  1'b0, 1'b1},
    '{1'b0, 1'b1, 1'b1, 8'd1,  1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 8'd29, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 8'd1,  1'b0, 1'b1},
    '{1'b1, 1'b1, 1'b0, 8'd3,  1'b0, 1'b1},
    '{1'b0, 1'b1, 1'b0, 8'd8,  1'b0, 1'b1},
    '{1'b1, 1'b1, 1'b0, 8'd5,  1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 8'd2,  1'b1, 1'b1},
    '{1'b1, 1'b1, 1'b0, 8'd8,  1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 8'd5,  1'b0, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  initial begin
    tick(1);
    hs_cmd = 1'b1; ls_cmd = 1'b1;
    tick(2);
    check(hs_out, 1'b0, "R1 hs_out in reset");
    check(ls_out, 1'b0, "R1 ls_out in reset");
    rst_n = 1'b1;
    tick(29);
    check(ls_out, 1'b0, "R7 ls_out one edge before qualification");
    tick(1);
    check(ls_out, 1'b1, "R7 ls_out at qualification");
    tick(15);
    check(hs_out, 1'b0, "R5 rise before hs supply valid is lost");
    hs_cmd = 1'b0; tick(2); hs_cmd = 1'b1;
    tick(5);
    check(hs_out, 1'b1, "R5 next rise turns on");

    hs_cmd = 1'b0; ls_cmd = 1'b0;
    tick(10);
    for (int i = 0; i < 15; i++) begin
      hs_cmd = VEC[i].hs; ls_cmd = VEC[i].ls; ls_uv = VEC[i].luv;
      tick(int'(VEC[i].hold));
      check(hs_out, VEC[i].ehs, $sformatf("R2 R3 R4 R8 hs_out vector %0d", i));
      check(ls_out, VEC[i].els, $sformatf("R7 ls_out vector %0d", i));
    end

    hs_cmd = 1'b1; tick(6);
    check(hs_out, 1'b1, "R2 on before supply loss");
    hs_uv = 1'b1; #1;
    check(hs_out, 1'b0, "R6 hs_out low same cycle as hs_uv");
    tick(3); hs_uv = 1'b0;
    tick(25);
    check(hs_out, 1'b0, "R6 latch stays cleared after recovery");
    hs_cmd = 1'b0; tick(2); hs_cmd = 1'b1; tick(5);
    check(hs_out, 1'b1, "R6 new rise after recovery turns on");

    hs_cmd = 1'b0; hs_uv = 1'b1; tick(6);
    hs_uv = 1'b0; tick(19); hs_cmd = 1'b1; tick(10);
    check(hs_out, 1'b0, "R5 rise one edge before qualification ignored");
    hs_cmd = 1'b0; hs_uv = 1'b1; tick(6);
    hs_uv = 1'b0; tick(20); hs_cmd = 1'b1; tick(4);
    check(hs_out, 1'b0, "R2 latency not yet elapsed");
    tick(1);
    check(hs_out, 1'b1, "R5 rise at qualification edge accepted");
    hs_cmd = 1'b0; tick(2);
    rst_n = 1'b0; tick(2);
    check(hs_out, 1'b0, "R1 hs_out after reset");
    check(ls_out, 1'b0, "R1 ls_out after reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule